// File: doc/BRIEF.md
# Core Event Latch / Mask / Pending Controller

This block sits between sixteen core event lines and the core's sequencer. Each line goes through a two-flop edge qualifier, and every qualified rising edge is recorded in a latch register. A mask register chooses which events may be serviced. Among the events that are latched, unmasked and not globally gated, the block picks the one with the lowest index. It offers that event to the core only when it outranks every event already in service.

The core takes an offered event through a valid/ready handshake. On acceptance the event's latch bit clears and its pending bit sets. Several pending bits can be set at once, one for each nesting level. A return strobe from the core retires the innermost level, which is the lowest-index pending bit. Software sees the three registers through a small register port. A pair of command strobes turns the global gate for the general-purpose levels on or off.

The issue interface follows these back-pressure rules. `iss_valid` and `iss_id` are combinational from the register state. An event is transferred only in a cycle where both `iss_valid` and `iss_ready` are high. While `iss_ready` is low, nothing changes state because of the offer. The offered `iss_id` may change to a higher-priority event that arrives in the meantime, and `iss_valid` may drop if a mask write or the global gate removes the event.

Top module: `ev_ctl_top`

## Requirements
- R1: After reset, the latch, mask and pending registers read 0, `iss_valid` is 0 and the global gate is disabled.
- R2: A 0-to-1 transition on `ev_in[i]` sets latch bit i at the second rising clock edge after the input changes. A line held high sets the bit only once.
- R3: An event whose mask bit is 0 still latches on an edge but is never offered. Mask bit 1 permits service.
- R4: Among events that are latched, unmasked and not gated, the lowest index is offered on `iss_id`.
- R5: When `iss_valid` and `iss_ready` are both high at a clock edge, the offered event's latch bit clears and its pending bit sets. The minimum delay from an input rising to its pending bit reading 1 is three rising edges.
- R6: An event is offered only if its index is lower than every set pending bit. Several pending bits may be set at once.
- R7: A `ret_strobe` pulse clears the lowest-index set pending bit at the next edge. It has no effect when nothing is pending.
- R8: A rising edge that arrives while the event's pending bit is set, or in the same cycle as its acceptance, latches the event again.
- R9: A register write to address 0 updates only the latch bits whose mask bit is 0. Latch bits with mask bit 1 keep their value.
- R10: The pending register is read-only. Writes to address 2 leave it unchanged.
- R11: Events 0 to 6 ignore the global gate. Events 7 to 15 are offered only while it is enabled. `glb_en_cmd` enables the gate and `glb_dis_cmd` disables it. When both are high in the same cycle, disable wins.
- R12: `reg_rdata` is combinational from `reg_addr`: 0 returns latch, 1 returns mask, 2 returns pending, and 3 returns 0. A write to address 1 loads the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 16 | Raw event lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| glb_en_cmd | input | 1 | Enable general-purpose levels |
| glb_dis_cmd | input | 1 | Disable general-purpose levels |
| iss_valid | output | 1 | An event is offered to the core |
| iss_ready | input | 1 | Core accepts the offered event |
| iss_id | output | 4 | Index of the offered event |
| ret_strobe | input | 1 | Core returns from the innermost event |

## Verification
A latch bit becomes readable two rising edges after its input rises. `iss_valid` and `iss_id` follow in the same cycle, because the selection is combinational. A pending bit appears one edge after an accepted handshake, a return takes effect one edge after the strobe, and register reads reflect the current state with no delay. The bench drives every input just after a falling edge and samples one time unit later. Its reference model advances exactly once per rising edge, so each comparison sees the result due for that cycle. Directed checks count edges from a known alignment to confirm the two-edge and three-edge latencies.

// File: rtl/ev_ctl_pkg.sv
package ev_ctl_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ev_edge_det.sv
module ev_edge_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= raw_i;
      stg2_q <= stg1_q;
    end
  end

  assign rise_o = stg1_q & ~stg2_q;
endmodule

// File: rtl/ev_prio_find.sv
module ev_prio_find #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ev_regs.sv
module ev_regs
  import ev_ctl_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  rise_i,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          acc_i,
  input  logic [IW-1:0] acc_id_i,
  input  logic          ret_i,
  input  logic          ret_found_i,
  input  logic [IW-1:0] ret_id_i,
  input  logic          en_cmd_i,
  input  logic          dis_cmd_i,
  output logic [W-1:0]  latch_o,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  pend_o,
  output logic          glb_en_o
);
  logic [W-1:0] latch_d, mask_d, pend_d;
  logic         glb_d;

  always_comb begin
    latch_d = latch_o;
    if (wr_i && sel_i == SEL_LATCH)
      latch_d = (latch_o & mask_o) | (wdata_i & ~mask_o);
    if (acc_i)
      latch_d[acc_id_i] = 1'b0;
    latch_d = latch_d | rise_i;

    mask_d = (wr_i && sel_i == SEL_MASK) ? wdata_i : mask_o;

    pend_d = pend_o;
    if (ret_i && ret_found_i)
      pend_d[ret_id_i] = 1'b0;
    if (acc_i)
      pend_d[acc_id_i] = 1'b1;

    if (dis_cmd_i)     glb_d = 1'b0;
    else if (en_cmd_i) glb_d = 1'b1;
    else               glb_d = glb_en_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_o  <= '0;
      mask_o   <= '0;
      pend_o   <= '0;
      glb_en_o <= 1'b0;
    end else begin
      latch_o  <= latch_d;
      mask_o   <= mask_d;
      pend_o   <= pend_d;
      glb_en_o <= glb_d;
    end
  end
endmodule

// File: rtl/ev_ctl_top.sv
module ev_ctl_top
  import ev_ctl_pkg::*;
#(
  parameter int NUM_EV     = 16,
  parameter int GATED_BASE = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_EV-1:0]          ev_in,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_addr,
  input  logic [NUM_EV-1:0]          reg_wdata,
  output logic [NUM_EV-1:0]          reg_rdata,
  input  logic                       glb_en_cmd,
  input  logic                       glb_dis_cmd,
  output logic                       iss_valid,
  input  logic                       iss_ready,
  output logic [$clog2(NUM_EV)-1:0]  iss_id,
  input  logic                       ret_strobe
);
  localparam int IDX_W = $clog2(NUM_EV);

  logic [NUM_EV-1:0] rise, latch_q, mask_q, pend_q, gate, elig;
  logic              glb_en_q, elig_found, pend_found, accept;
  logic [IDX_W-1:0]  elig_id, pend_id;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(reg_addr);

  ev_edge_det #(.W(NUM_EV)) edge_i (
    .clk(clk), .rst_n(rst_n), .raw_i(ev_in), .rise_o(rise)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_gate
    if (g < GATED_BASE) begin : g_core
      assign gate[g] = 1'b1;
    end else begin : g_gp
      assign gate[g] = glb_en_q;
    end
  end

  assign elig = latch_q & mask_q & gate;

  ev_prio_find #(.W(NUM_EV), .IW(IDX_W)) elig_find_i (
    .vec_i(elig), .found_o(elig_found), .idx_o(elig_id)
  );

  ev_prio_find #(.W(NUM_EV), .IW(IDX_W)) pend_find_i (
    .vec_i(pend_q), .found_o(pend_found), .idx_o(pend_id)
  );

  assign iss_valid = elig_found && (!pend_found || elig_id < pend_id);
  assign iss_id    = elig_id;
  assign accept    = iss_valid && iss_ready;

  ev_regs #(.W(NUM_EV), .IW(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .wr_i(reg_wr), .sel_i(sel), .wdata_i(reg_wdata),
    .acc_i(accept), .acc_id_i(elig_id),
    .ret_i(ret_strobe), .ret_found_i(pend_found), .ret_id_i(pend_id),
    .en_cmd_i(glb_en_cmd), .dis_cmd_i(glb_dis_cmd),
    .latch_o(latch_q), .mask_o(mask_q), .pend_o(pend_q), .glb_en_o(glb_en_q)
  );

  always_comb begin
    case (sel)
      SEL_LATCH: reg_rdata = latch_q;
      SEL_MASK:  reg_rdata = mask_q;
      SEL_PEND:  reg_rdata = pend_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ev_ctl_chk.sv
module ev_ctl_chk #(
  parameter int NUM_EV     = 16,
  parameter int GATED_BASE = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic                      iss_ready,
  input logic [$clog2(NUM_EV)-1:0] iss_id,
  input logic                      ret_strobe,
  input logic                      reg_wr,
  input logic [1:0]                reg_addr,
  input logic [NUM_EV-1:0]         latch_q,
  input logic [NUM_EV-1:0]         mask_q,
  input logic [NUM_EV-1:0]         pend_q,
  input logic                      glb_en_q
);
  logic [NUM_EV-1:0] upto_id, below_id;
  logic              acc;

  assign upto_id  = ((NUM_EV'(1) << iss_id) << 1) - NUM_EV'(1);
  assign below_id = (NUM_EV'(1) << iss_id) - NUM_EV'(1);
  assign acc      = iss_valid && iss_ready;

  AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (mask_q[iss_id] && latch_q[iss_id])); // R3

  AST_OFFER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ((latch_q & mask_q & below_id & {NUM_EV{glb_en_q}}) == '0)); // R4

  AST_ACCEPT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> pend_q[$past(iss_id)]); // R5

  AST_NEST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ((pend_q & upto_id) == '0)); // R6

  AST_RETURN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && pend_q != '0 && !acc) |=>
      ($countones(pend_q) + 1 == $countones($past(pend_q)))); // R7

  AST_PEND_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !ret_strobe && !acc) |=> $stable(pend_q)); // R10

  AST_GATED_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && int'(iss_id) >= GATED_BASE) |-> glb_en_q); // R11
endmodule

bind ev_ctl_top ev_ctl_chk #(.NUM_EV(NUM_EV), .GATED_BASE(GATED_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_id(iss_id), .ret_strobe(ret_strobe), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .latch_q(latch_q), .mask_q(mask_q), .pend_q(pend_q), .glb_en_q(glb_en_q)
);

// File: tb/ev_ctl_top_tb_top.sv
module ev_ctl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int GB = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] ev_in = '0, reg_wdata = '0, reg_rdata;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 0, glb_en_cmd = 0, glb_dis_cmd = 0, iss_ready = 0, ret_strobe = 0;
  logic iss_valid;
  logic [3:0] iss_id;

  int n_cmp = 0, n_bad = 0;

  logic [W-1:0] m_s1 = '0, m_s2 = '0, m_lat = '0, m_msk = '0, m_pnd = '0;
  logic m_glb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ev_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glb_en_cmd(glb_en_cmd),
    .glb_dis_cmd(glb_dis_cmd), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_id(iss_id), .ret_strobe(ret_strobe)
  );

  function automatic int lowest(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) if (v[i]) return i;
    return W;
  endfunction

  function automatic logic [W-1:0] m_elig();
    logic [W-1:0] g;
    for (int i = 0; i < W; i++) g[i] = (i < GB) ? 1'b1 : m_glb;
    return m_lat & m_msk & g;
  endfunction

  function automatic logic m_valid();
    return lowest(m_elig()) < W && lowest(m_elig()) < lowest(m_pnd);
  endfunction

  function automatic logic [W-1:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_lat;
      2'd1: return m_msk;
      2'd2: return m_pnd;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [W-1:0] rise, nl, np;
    int sel, pl;
    logic acc;
    rise = m_s1 & ~m_s2;
    sel = lowest(m_elig());
    pl = lowest(m_pnd);
    acc = m_valid() && iss_ready;
    nl = m_lat;
    if (reg_wr && reg_addr == 2'd0) nl = (m_lat & m_msk) | (reg_wdata & ~m_msk);
    if (acc) nl[sel] = 1'b0;
    nl = nl | rise;
    np = m_pnd;
    if (ret_strobe && pl < W) np[pl] = 1'b0;
    if (acc) np[sel] = 1'b1;
    if (reg_wr && reg_addr == 2'd1) m_msk = reg_wdata;
    if (glb_dis_cmd) m_glb = 0; else if (glb_en_cmd) m_glb = 1;
    m_lat = nl;
    m_pnd = np;
    m_s2 = m_s1;
    m_s1 = ev_in;
  endtask

  task automatic cycle();
    #1;
    chk("R4 offer valid", int'(iss_valid), int'(m_valid()));
    if (m_valid()) chk("R4 offer id", int'(iss_id), lowest(m_elig()));
    chk("R12 read data", int'(reg_rdata), int'(m_read(reg_addr)));
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr = 0;
  endtask

  task automatic peek(input logic [1:0] a);
    reg_addr = a;
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(0); chk("R1 latch", int'(reg_rdata), 0);
    peek(1); chk("R1 mask", int'(reg_rdata), 0);
    peek(2); chk("R1 pend", int'(reg_rdata), 0);
    chk("R1 valid", int'(iss_valid), 0);
    wr(2'd1, 16'hFFFF);
    ev_in[9] = 1; idle(3);
    peek(0); chk("R2 latch bit9", int'(reg_rdata), 'h0200);
    chk("R11 gated level held back", int'(iss_valid), 0);
    ev_in[5] = 1; idle(1);
    peek(0); chk("R2 one edge too early", int'(reg_rdata), 'h0200);
    idle(1);
    peek(0); chk("R2 second edge", int'(reg_rdata), 'h0220);
    chk("R11 ungated level offered", int'(iss_valid), 1);
    chk("R11 ungated id", int'(iss_id), 5);
    glb_en_cmd = 1; cycle(); glb_en_cmd = 0;
    chk("R4 lowest wins", int'(iss_id), 5);
    iss_ready = 1; idle(1);
    peek(2); chk("R5 pend after accept", int'(reg_rdata), 'h0020);
    peek(0); chk("R5 latch cleared", int'(reg_rdata), 'h0200);
    chk("R6 lower level blocked", int'(iss_valid), 0);
    ev_in[1] = 1; idle(3);
    peek(2); chk("R5 three edge latency / R6 nest", int'(reg_rdata), 'h0022);
    iss_ready = 0;
    ev_in[5] = 0; idle(2); ev_in[5] = 1; idle(2);
    peek(0); chk("R8 relatch while pending", int'(reg_rdata), 'h0220);
    ret_strobe = 1; cycle(); ret_strobe = 0;
    peek(2); chk("R7 innermost retired", int'(reg_rdata), 'h0020);
    chk("R6 equal level not offered", int'(iss_valid), 0);
    ret_strobe = 1; cycle(); ret_strobe = 0;
    peek(2); chk("R7 second return", int'(reg_rdata), 0);
    chk("R8 requeued offer", int'(iss_id), 5);
    wr(2'd2, 16'hFFFF);
    peek(2); chk("R10 pend unchanged", int'(reg_rdata), 0);
    wr(2'd1, 16'h00FF);
    ev_in[10] = 1; idle(2);
    peek(0); chk("R3 masked still latches", int'(reg_rdata), 'h0620);
    chk("R3 masked not offered", int'(iss_id), 5);
    wr(2'd0, 16'hF000);
    peek(0); chk("R9 masked write", int'(reg_rdata), 'hF020);
    peek(3); chk("R12 unused address", int'(reg_rdata), 0);
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0100); wr(2'd1, 16'h0100);
    glb_en_cmd = 1; glb_dis_cmd = 1; cycle(); glb_en_cmd = 0; glb_dis_cmd = 0;
    chk("R11 disable wins", int'(iss_valid), 0);
    glb_en_cmd = 1; cycle(); glb_en_cmd = 0;
    chk("R11 enabled level 8", int'(iss_valid), 1);
    chk("R11 enabled id", int'(iss_id), 8);
    for (int k = 0; k < 2000; k++) begin
      if ($urandom % 4 == 0) ev_in[$urandom % W] ^= 1'b1;
      iss_ready   = ($urandom % 2) == 0;
      ret_strobe  = ($urandom % 6) == 0;
      reg_wr      = ($urandom % 5) == 0;
      reg_addr    = 2'($urandom % 4);
      reg_wdata   = W'($urandom);
      glb_en_cmd  = ($urandom % 10) == 0;
      glb_dis_cmd = ($urandom % 12) == 0;
      cycle();
    end
    finish_run();
  end
endmodule